// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block decides which DMA transfer mode a host should use with an attached storage drive. It receives the drive's identification content (the supported-mode bytes of the three DMA classes, two field-valid flags, a legacy single-word timing number and the drive's capability flags), together with host-side capability masks, an 80-conductor cable indication, a media-type flag and a host switch that allows DMA to non-disk (packet) devices.

A one-cycle request starts an evaluation. One clock later the block raises a valid strobe for a single cycle and presents an 8-bit mode code. The code is a class base plus a mode number: 0x40 for Ultra DMA, 0x20 for multiword DMA and 0x10 for single-word DMA. A code of zero means DMA must not be used. The code holds its value until the next request. Classes are tried from fastest to slowest. Within the first class whose filtered mask is non-empty, the highest set bit gives the mode number.

Top module: `dmp_mode_pick`

## Requirements
- R1: After synchronous reset, `res_vld` is 0 and `res_code` is 0x00.
- R2: `res_vld` is high exactly in the cycle after a cycle with `req` high, and low otherwise. `res_code` changes only in a cycle where `res_vld` is high, and holds its value between requests.
- R3: Class priority is fixed: Ultra DMA first, then multiword, then single-word. A slower class is used only when every faster class has an empty filtered mask.
- R4: Within the winning class, the mode number is the index of the highest set bit of its filtered mask. `res_code` is the class base (0x40 Ultra, 0x20 multiword, 0x10 single-word) plus that index.
- R5: The Ultra mask is `ultra_modes & host_ultra_mask`. It is treated as empty when `ultra_fv` (field-valid bit 2) is 0.
- R6: When `cable80` is 0 and the Ultra mask has any of bits 3..6 set, the Ultra mask is cut down to its bits 0..2. Bit 7 is not subject to this cut.
- R7: The multiword mask is `mw_modes & host_mw_mask`, and the single-word mask is `sw_modes & host_sw_mask`. Both are empty when `words_fv` (field-valid bit 1) is 0, apart from the fallback in R8.
- R8: When `words_fv` is 0 and `legacy_sw_mode` is 1 or 2, the single-word mask is `((2 << legacy_sw_mode) - 1) & host_sw_mask`. Any other `legacy_sw_mode` value gives an empty single-word mask.
- R9: When `is_disk` is 0 and `atapi_dma_en` is 0, the code is 0x00.
- R10: When `dma_cap` is 0 or `auto_dma` is 0, the code is 0x00.
- R11: When every class mask is empty, the code is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start an evaluation (single cycle) |
| dma_cap | input | 1 | Drive reports DMA capability |
| auto_dma | input | 1 | Automatic DMA allowed for this drive |
| is_disk | input | 1 | Device is a disk (not a packet device) |
| atapi_dma_en | input | 1 | Host permits DMA to non-disk devices |
| cable80 | input | 1 | 80-conductor cable detected |
| ultra_fv | input | 1 | Ultra mode byte is valid (field-valid bit 2) |
| words_fv | input | 1 | Multi/single-word bytes are valid (field-valid bit 1) |
| ultra_modes | input | 8 | Drive-supported Ultra DMA modes, one bit per mode |
| mw_modes | input | 8 | Drive-supported multiword DMA modes |
| sw_modes | input | 8 | Drive-supported single-word DMA modes |
| legacy_sw_mode | input | 8 | Legacy single-word timing mode number |
| host_ultra_mask | input | 8 | Host-supported Ultra modes |
| host_mw_mask | input | 8 | Host-supported multiword modes |
| host_sw_mask | input | 8 | Host-supported single-word modes |
| res_vld | output | 1 | Result valid, one cycle after `req` |
| res_code | output | 8 | Selected mode code, 0x00 = no DMA |

## Verification
A broken mask stage or priority chain shows up at the ports in the first `res_vld` cycle after the request. It appears as a wrong class base or a wrong mode number, because the block keeps no state between requests except the held code. The directed cases are chosen so that each filter (field-valid gating, host masks, cable cut, legacy fallback, media and capability gating) is the only reason a different code would appear. A wrong hold or strobe register shows up as a code change or a `res_vld` level in the cycle after the strobe.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  localparam int MW     = 8;
  localparam int IDX_W  = $clog2(MW);
  localparam int NCLS   = 3;

  localparam int CLS_ULTRA = 0;
  localparam int CLS_MW    = 1;
  localparam int CLS_SW    = 2;

  localparam logic [MW-1:0] CABLE_HI = 8'h78;
  localparam logic [MW-1:0] CABLE_LO = 8'h07;

  function automatic logic [7:0] class_base(input int k);
    case (k)
      CLS_ULTRA: class_base = 8'h40;
      CLS_MW:    class_base = 8'h20;
      default:   class_base = 8'h10;
    endcase
  endfunction
endpackage

// File: rtl/dmp_mask_build.sv
module dmp_mask_build
  import dmp_pkg::*;
(
  input  logic          cable80,
  input  logic          ultra_fv,
  input  logic          words_fv,
  input  logic [MW-1:0] ultra_modes,
  input  logic [MW-1:0] mw_modes,
  input  logic [MW-1:0] sw_modes,
  input  logic [7:0]    legacy_sw_mode,
  input  logic [MW-1:0] host_ultra_mask,
  input  logic [MW-1:0] host_mw_mask,
  input  logic [MW-1:0] host_sw_mask,
  output logic [MW-1:0] ultra_mask,
  output logic [MW-1:0] mw_mask,
  output logic [MW-1:0] sw_mask
);
  localparam logic [MW-1:0] ONE = MW'(1);

  logic [MW-1:0] ultra_raw;
  logic [MW-1:0] legacy_mask;
  logic          legacy_ok;

  always_comb begin
    ultra_raw = ultra_fv ? (ultra_modes & host_ultra_mask) : '0;
    if (!cable80 && |(ultra_raw & CABLE_HI))
      ultra_mask = ultra_raw & CABLE_LO;
    else
      ultra_mask = ultra_raw;
  end

  always_comb begin
    legacy_ok   = (legacy_sw_mode == 8'd1) || (legacy_sw_mode == 8'd2);
    legacy_mask = (ONE << (legacy_sw_mode[1:0] + 2'd1)) - ONE;
    mw_mask     = words_fv ? (mw_modes & host_mw_mask) : '0;
    if (words_fv)
      sw_mask = sw_modes & host_sw_mask;
    else if (legacy_ok)
      sw_mask = legacy_mask & host_sw_mask;
    else
      sw_mask = '0;
  end
endmodule

// File: rtl/dmp_msb_find.sv
module dmp_msb_find #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dmp_mode_pick.sv
module dmp_mode_pick
  import dmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       dma_cap,
  input  logic       auto_dma,
  input  logic       is_disk,
  input  logic       atapi_dma_en,
  input  logic       cable80,
  input  logic       ultra_fv,
  input  logic       words_fv,
  input  logic [7:0] ultra_modes,
  input  logic [7:0] mw_modes,
  input  logic [7:0] sw_modes,
  input  logic [7:0] legacy_sw_mode,
  input  logic [7:0] host_ultra_mask,
  input  logic [7:0] host_mw_mask,
  input  logic [7:0] host_sw_mask,
  output logic       res_vld,
  output logic [7:0] res_code
);
  logic [MW-1:0]    cls_mask  [NCLS];
  logic             cls_found [NCLS];
  logic [IDX_W-1:0] cls_idx   [NCLS];
  logic             allow;
  logic [7:0]       code_nxt;

  dmp_mask_build masks_i (
    .cable80         (cable80),
    .ultra_fv        (ultra_fv),
    .words_fv        (words_fv),
    .ultra_modes     (ultra_modes),
    .mw_modes        (mw_modes),
    .sw_modes        (sw_modes),
    .legacy_sw_mode  (legacy_sw_mode),
    .host_ultra_mask (host_ultra_mask),
    .host_mw_mask    (host_mw_mask),
    .host_sw_mask    (host_sw_mask),
    .ultra_mask      (cls_mask[CLS_ULTRA]),
    .mw_mask         (cls_mask[CLS_MW]),
    .sw_mask         (cls_mask[CLS_SW])
  );

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    dmp_msb_find #(.W(MW), .IDX_W(IDX_W)) msb_i (
      .vec   (cls_mask[k]),
      .found (cls_found[k]),
      .idx   (cls_idx[k])
    );
  end

  always_comb begin
    allow    = dma_cap && auto_dma && (is_disk || atapi_dma_en);
    code_nxt = 8'h00;
    for (int k = NCLS - 1; k >= 0; k--) begin
      if (cls_found[k])
        code_nxt = class_base(k) + 8'(cls_idx[k]);
    end
    if (!allow)
      code_nxt = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_code <= 8'h00;
    end else begin
      res_vld <= req;
      if (req)
        res_code <= code_nxt;
    end
  end

  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req |=> res_vld);                                             // R2
  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req |=> !res_vld);                                           // R2
  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(res_code));                                  // R2
  AST_GATE_CAP: assert property (@(posedge clk) disable iff (rst)
    (req && (!dma_cap || !auto_dma)) |=> (res_code == 8'h00));    // R10
  AST_GATE_MEDIA: assert property (@(posedge clk) disable iff (rst)
    (req && !is_disk && !atapi_dma_en) |=> (res_code == 8'h00));  // R9
  AST_CABLE_CUT: assert property (@(posedge clk) disable iff (rst)
    (req && !cable80) |=> !(res_code inside {[8'h43:8'h46]}));    // R6
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $onehot0({res_code[6], res_code[5], res_code[4]})); // R3
endmodule

// File: tb/dmp_mode_pick_tb_top.sv
module dmp_mode_pick_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       req;
  logic       dma_cap, auto_dma, is_disk, atapi_dma_en, cable80, ultra_fv, words_fv;
  logic [7:0] ultra_modes, mw_modes, sw_modes, legacy_sw_mode;
  logic [7:0] host_ultra_mask, host_mw_mask, host_sw_mask;
  logic       res_vld;
  logic [7:0] res_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dmp_mode_pick dut_i (
    .clk (clk), .rst (rst), .req (req),
    .dma_cap (dma_cap), .auto_dma (auto_dma), .is_disk (is_disk),
    .atapi_dma_en (atapi_dma_en), .cable80 (cable80),
    .ultra_fv (ultra_fv), .words_fv (words_fv),
    .ultra_modes (ultra_modes), .mw_modes (mw_modes), .sw_modes (sw_modes),
    .legacy_sw_mode (legacy_sw_mode),
    .host_ultra_mask (host_ultra_mask), .host_mw_mask (host_mw_mask),
    .host_sw_mask (host_sw_mask),
    .res_vld (res_vld), .res_code (res_code)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic defaults();
    dma_cap = 1; auto_dma = 1; is_disk = 1; atapi_dma_en = 0; cable80 = 1;
    ultra_fv = 1; words_fv = 1;
    ultra_modes = 8'h00; mw_modes = 8'h00; sw_modes = 8'h00; legacy_sw_mode = 8'h00;
    host_ultra_mask = 8'hFF; host_mw_mask = 8'hFF; host_sw_mask = 8'hFF;
  endtask

  // one request; checks strobe, code, then strobe drop and code hold
  task automatic run(input string tag, input logic [7:0] exp);
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    chk({tag, " R2 vld"}, {7'd0, res_vld}, 8'h01);
    chk(tag, res_code, exp);
    @(negedge clk);
    chk({tag, " R2 vld drop"}, {7'd0, res_vld}, 8'h00);
    chk({tag, " R2 hold"}, res_code, exp);
  endtask

  task automatic t_reset();
    chk("R1 vld", {7'd0, res_vld}, 8'h00);
    chk("R1 code", res_code, 8'h00);
  endtask

  task automatic t_priority();
    defaults(); ultra_modes = 8'h3F; mw_modes = 8'h07; sw_modes = 8'h07;
    run("R3 R4 ultra wins", 8'h45);
    defaults(); ultra_modes = 8'h3F; host_ultra_mask = 8'h00; mw_modes = 8'h05; sw_modes = 8'h07;
    run("R3 mw after empty ultra", 8'h22);
    defaults(); mw_modes = 8'h05; host_mw_mask = 8'h00; sw_modes = 8'h03;
    run("R3 R7 sw last", 8'h11);
  endtask

  task automatic t_ultra();
    defaults(); ultra_modes = 8'h3F; host_ultra_mask = 8'h07;
    run("R5 host mask", 8'h42);
    defaults(); ultra_fv = 0; ultra_modes = 8'hFF; mw_modes = 8'h03;
    run("R5 ultra invalid", 8'h21);
    defaults(); cable80 = 0; ultra_modes = 8'h3F;
    run("R6 cable cut", 8'h42);
    defaults(); cable80 = 0; ultra_modes = 8'h80;
    run("R6 bit7 kept", 8'h47);
    defaults(); cable80 = 0; ultra_modes = 8'h78; mw_modes = 8'h01;
    run("R6 cut to empty", 8'h20);
  endtask

  task automatic t_words();
    defaults(); ultra_fv = 0; words_fv = 0; mw_modes = 8'hFF; sw_modes = 8'hFF;
    run("R7 words invalid", 8'h00);
    defaults(); ultra_fv = 0; mw_modes = 8'h01; sw_modes = 8'h07;
    run("R7 mw mode0", 8'h20);
  endtask

  task automatic t_legacy();
    defaults(); ultra_fv = 0; words_fv = 0; legacy_sw_mode = 8'd2;
    run("R8 legacy 2", 8'h12);
    defaults(); ultra_fv = 0; words_fv = 0; legacy_sw_mode = 8'd1;
    run("R8 legacy 1", 8'h11);
    defaults(); ultra_fv = 0; words_fv = 0; legacy_sw_mode = 8'd3;
    run("R8 legacy 3", 8'h00);
    defaults(); ultra_fv = 0; words_fv = 0; legacy_sw_mode = 8'd0;
    run("R8 legacy 0", 8'h00);
    defaults(); ultra_fv = 0; words_fv = 0; legacy_sw_mode = 8'd2; host_sw_mask = 8'h01;
    run("R8 legacy host", 8'h10);
  endtask

  task automatic t_gates();
    defaults(); is_disk = 0; ultra_modes = 8'h3F;
    run("R9 packet no dma", 8'h00);
    defaults(); is_disk = 0; atapi_dma_en = 1; ultra_modes = 8'h3F;
    run("R9 packet dma", 8'h45);
    defaults(); dma_cap = 0; ultra_modes = 8'h3F;
    run("R10 no cap", 8'h00);
    defaults(); auto_dma = 0; ultra_modes = 8'h3F;
    run("R10 no auto", 8'h00);
    defaults();
    run("R11 empty", 8'h00);
  endtask

  initial begin
    defaults();
    req = 1'b0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_priority();
    t_ultra();
    t_words();
    t_legacy();
    t_gates();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule